// File: doc/BRIEF.md
# Bus Timing Nanosecond-to-Cycle Compiler

This block turns the timing needs of an external static memory, written in nanoseconds, into the whole clock-cycle counts that a static memory interface is programmed with. The caller presents the interface clock frequency in Hz and fourteen nanosecond values. These are setup, pulse and recovery for each of four strobes (read chip-select, read strobe, write chip-select, write strobe), plus a minimum read period and a minimum write period. The caller then pulses `start_i`. Some time later `done_o` pulses for one clock. From that clock on, the outputs hold the four setup counts, the four pulse counts and the read and write period counts. They keep these values until the next accepted start.

The work is done by a sequential state machine that reuses one restoring divider and one multiplier. The states are `ST_IDLE`, `ST_SCALE_GO`, `ST_SCALE_WAIT`, `ST_MUL_GO`, `ST_MUL_WAIT`, `ST_CONVERT`, `ST_STRETCH` and `ST_FINISH`, and they move as follows:
- A start pulse moves `ST_IDLE` to `ST_SCALE_GO`, which launches the divide of the frequency by 10000.
- `ST_SCALE_GO` always moves to `ST_SCALE_WAIT`, which waits for the divider.
- The divider finishing moves `ST_SCALE_WAIT` to `ST_MUL_GO`, which launches the divide of that quotient (shifted left 16) by 100000.
- `ST_MUL_GO` always moves to `ST_MUL_WAIT`.
- The divider finishing moves `ST_MUL_WAIT` to `ST_CONVERT`. `ST_CONVERT` converts one stored value per clock, and after the fourteenth it moves to `ST_STRETCH`.
- `ST_STRETCH` computes both periods and always moves to `ST_FINISH`.
- `ST_FINISH` loads the saturated results, raises `done_o` and returns to `ST_IDLE`.

Top module: `nsc_timing_compiler`

## Requirements
- R1: After reset every count output is zero and `done_o` is low.
- R2: The fixed-point scale is M = floor(floor(F / 10000) * 65536 / 100000), where F is the latched frequency in Hz.
- R3: Each nonzero setup, pulse or minimum-period value x converts to floor((x * M + 65535) / 65536) cycles, which is the rounded-up count.
- R4: A setup, pulse or minimum-period value of zero gives a count of zero without conversion.
- R5: A recovery value of zero counts as one cycle. A nonzero recovery value converts by the R3 rule.
- R6: The read period is the largest of three terms: the converted minimum read period, the read chip-select setup + pulse + recovery, and the read strobe setup + pulse + recovery.
- R7: The write period is the largest of three terms: the converted minimum write period, the write chip-select setup + pulse + recovery, and the write strobe setup + pulse + recovery.
- R8: When a start is accepted, all count outputs become zero on the next clock. They stay zero until results are delivered.
- R9: `done_o` is high for exactly one clock. The new counts appear on that same clock and hold until the next accepted start.
- R10: Results saturate to their field widths: setup counts at 63 (6 bits), pulse counts at 127 (7 bits), and period counts at 511 (9 bits).
- R11: A start pulse while a computation runs is ignored. The inputs latched at the accepted start are used, and later input changes have no effect on that run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a computation (accepted in idle only) |
| freq_hz_i | input | 32 | Interface clock frequency in Hz |
| rcs_setup_ns_i | input | 16 | Read chip-select setup, ns |
| rstb_setup_ns_i | input | 16 | Read strobe setup, ns |
| wcs_setup_ns_i | input | 16 | Write chip-select setup, ns |
| wstb_setup_ns_i | input | 16 | Write strobe setup, ns |
| rcs_pulse_ns_i | input | 16 | Read chip-select pulse, ns |
| rstb_pulse_ns_i | input | 16 | Read strobe pulse, ns |
| wcs_pulse_ns_i | input | 16 | Write chip-select pulse, ns |
| wstb_pulse_ns_i | input | 16 | Write strobe pulse, ns |
| rd_period_ns_i | input | 16 | Minimum read period, ns |
| wr_period_ns_i | input | 16 | Minimum write period, ns |
| rcs_recover_ns_i | input | 16 | Read chip-select recovery, ns |
| rstb_recover_ns_i | input | 16 | Read strobe recovery, ns |
| wcs_recover_ns_i | input | 16 | Write chip-select recovery, ns |
| wstb_recover_ns_i | input | 16 | Write strobe recovery, ns |
| rcs_setup_cyc_o | output | 6 | Read chip-select setup, cycles |
| rstb_setup_cyc_o | output | 6 | Read strobe setup, cycles |
| wcs_setup_cyc_o | output | 6 | Write chip-select setup, cycles |
| wstb_setup_cyc_o | output | 6 | Write strobe setup, cycles |
| rcs_pulse_cyc_o | output | 7 | Read chip-select pulse, cycles |
| rstb_pulse_cyc_o | output | 7 | Read strobe pulse, cycles |
| wcs_pulse_cyc_o | output | 7 | Write chip-select pulse, cycles |
| wstb_pulse_cyc_o | output | 7 | Write strobe pulse, cycles |
| rd_period_cyc_o | output | 9 | Read period, cycles |
| wr_period_cyc_o | output | 9 | Write period, cycles |
| done_o | output | 1 | One-clock completion pulse |

## Verification
The hardest situation to reach from the ports is a start pulse that arrives while the divider is still busy, combined with input values that change during the same run. Getting there shows whether the latched copy, and not the live ports, feeds the conversion. The bench launches one run and waits ten clocks, so the first divide is still in progress. It then presents a completely different input set and fires a second start. It expects the results of the first set and exactly one `done_o` pulse. A scale of zero is also reached on purpose, by giving a frequency below 10000 Hz. In that case every nonzero value rounds to zero cycles, while zero recoveries still count as one.

// File: rtl/nsc_pkg.sv
package nsc_pkg;

    localparam int N_ITEMS       = 14;
    localparam int FIRST_RECOVER = 10;
    localparam int ITEM_IDX_W    = $clog2(N_ITEMS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SCALE_GO,
        ST_SCALE_WAIT,
        ST_MUL_GO,
        ST_MUL_WAIT,
        ST_CONVERT,
        ST_STRETCH,
        ST_FINISH
    } nsc_state_e;

    // Slot order of the latched nanosecond values; stretch sums depend on it.
    localparam int IX_RCS_SETUP   = 0;
    localparam int IX_RSTB_SETUP  = 1;
    localparam int IX_WCS_SETUP   = 2;
    localparam int IX_WSTB_SETUP  = 3;
    localparam int IX_RCS_PULSE   = 4;
    localparam int IX_RSTB_PULSE  = 5;
    localparam int IX_WCS_PULSE   = 6;
    localparam int IX_WSTB_PULSE  = 7;
    localparam int IX_RD_PERIOD   = 8;
    localparam int IX_WR_PERIOD   = 9;
    localparam int IX_RCS_RECOVER = 10;
    localparam int IX_RSTB_RECOVER= 11;
    localparam int IX_WCS_RECOVER = 12;
    localparam int IX_WSTB_RECOVER= 13;

endpackage

// File: rtl/nsc_divider.sv
module nsc_divider #(
    parameter int W = 48
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         start_i,
    input  logic [W-1:0] dividend_i,
    input  logic [W-1:0] divisor_i,
    output logic [W-1:0] quotient_o,
    output logic         done_o
);
    localparam int CNT_W = $clog2(W + 1);
    localparam int CHK_W = 2 * W + 1;

    logic [W-1:0]     dvd_q, dvs_q, quo_q;
    logic [W:0]       rem_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q, done_q;
    logic [W:0]       shifted, diff;

    always_comb begin
        shifted = {rem_q[W-1:0], quo_q[W-1]};
        diff    = shifted - {1'b0, dvs_q};
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dvd_q  <= '0;
            dvs_q  <= '0;
            quo_q  <= '0;
            rem_q  <= '0;
            cnt_q  <= '0;
            run_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            done_q <= run_q && (cnt_q == CNT_W'(1));
            if (start_i) begin
                dvd_q <= dividend_i;
                dvs_q <= divisor_i;
                quo_q <= dividend_i;
                rem_q <= '0;
                cnt_q <= CNT_W'(W);
                run_q <= 1'b1;
            end else if (run_q) begin
                if (!diff[W]) begin
                    rem_q <= diff;
                    quo_q <= {quo_q[W-2:0], 1'b1};
                end else begin
                    rem_q <= shifted;
                    quo_q <= {quo_q[W-2:0], 1'b0};
                end
                cnt_q <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) run_q <= 1'b0;
            end
        end
    end

    assign quotient_o = quo_q;
    assign done_o     = done_q;

    // The delivered quotient must be the floor of the latched operands (feeds R2).
    assert_div_floor_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_q && dvs_q != '0) |->
            ((CHK_W'(quo_q) * CHK_W'(dvs_q) <= CHK_W'(dvd_q)) &&
             (CHK_W'(dvd_q) < CHK_W'(quo_q) * CHK_W'(dvs_q) + CHK_W'(dvs_q))));

    assert_div_done_pulse_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_q |=> !done_q);

endmodule

// File: rtl/nsc_saturate.sv
module nsc_saturate #(
    parameter int IN_W  = 49,
    parameter int OUT_W = 6
) (
    input  logic [IN_W-1:0]  value_i,
    output logic [OUT_W-1:0] value_o
);
    localparam logic [IN_W-1:0] LIMIT = {{(IN_W-OUT_W){1'b0}}, {OUT_W{1'b1}}};

    always_comb begin
        if (value_i > LIMIT) value_o = '1;
        else                 value_o = value_i[OUT_W-1:0];
    end

endmodule

// File: rtl/nsc_timing_compiler.sv
module nsc_timing_compiler
    import nsc_pkg::*;
#(
    parameter int FREQ_W  = 32,
    parameter int NS_W    = 16,
    parameter int SETUP_W = 6,
    parameter int PULSE_W = 7,
    parameter int CYCLE_W = 9
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               start_i,
    input  logic [FREQ_W-1:0]  freq_hz_i,
    input  logic [NS_W-1:0]    rcs_setup_ns_i,
    input  logic [NS_W-1:0]    rstb_setup_ns_i,
    input  logic [NS_W-1:0]    wcs_setup_ns_i,
    input  logic [NS_W-1:0]    wstb_setup_ns_i,
    input  logic [NS_W-1:0]    rcs_pulse_ns_i,
    input  logic [NS_W-1:0]    rstb_pulse_ns_i,
    input  logic [NS_W-1:0]    wcs_pulse_ns_i,
    input  logic [NS_W-1:0]    wstb_pulse_ns_i,
    input  logic [NS_W-1:0]    rd_period_ns_i,
    input  logic [NS_W-1:0]    wr_period_ns_i,
    input  logic [NS_W-1:0]    rcs_recover_ns_i,
    input  logic [NS_W-1:0]    rstb_recover_ns_i,
    input  logic [NS_W-1:0]    wcs_recover_ns_i,
    input  logic [NS_W-1:0]    wstb_recover_ns_i,
    output logic [SETUP_W-1:0] rcs_setup_cyc_o,
    output logic [SETUP_W-1:0] rstb_setup_cyc_o,
    output logic [SETUP_W-1:0] wcs_setup_cyc_o,
    output logic [SETUP_W-1:0] wstb_setup_cyc_o,
    output logic [PULSE_W-1:0] rcs_pulse_cyc_o,
    output logic [PULSE_W-1:0] rstb_pulse_cyc_o,
    output logic [PULSE_W-1:0] wcs_pulse_cyc_o,
    output logic [PULSE_W-1:0] wstb_pulse_cyc_o,
    output logic [CYCLE_W-1:0] rd_period_cyc_o,
    output logic [CYCLE_W-1:0] wr_period_cyc_o,
    output logic               done_o
);
    localparam int FRAC_W  = 16;
    localparam int DIV_W   = FREQ_W + FRAC_W;
    localparam int PROD_W  = NS_W + DIV_W + 1;
    localparam int RAW_W   = PROD_W - FRAC_W;
    localparam int SUM_W   = RAW_W + 2;
    localparam int N_GROUP = 4;
    localparam logic [DIV_W-1:0] SCALE_DIV = DIV_W'(10000);
    localparam logic [DIV_W-1:0] MUL_DIV   = DIV_W'(100000);
    localparam logic [PROD_W-1:0] ROUND_UP = PROD_W'((1 << FRAC_W) - 1);

    nsc_state_e state_q, state_d;

    logic [FREQ_W-1:0]     freq_q;
    logic [NS_W-1:0]       ns_q   [N_ITEMS];
    logic [RAW_W-1:0]      raw_q  [N_ITEMS];
    logic [DIV_W-1:0]      scale_q, mul_q;
    logic [ITEM_IDX_W-1:0] idx_q;
    logic [SUM_W-1:0]      per_q  [2];

    logic [NS_W-1:0]       ns_live [N_ITEMS];
    logic                  accept;
    logic                  div_start, div_done;
    logic [DIV_W-1:0]      div_dividend, div_divisor, div_quotient;
    logic [PROD_W-1:0]     prod, prod_round;
    logic [RAW_W-1:0]      conv_val;
    logic [SUM_W-1:0]      rd_sum_cs, rd_sum_stb, wr_sum_cs, wr_sum_stb;

    logic [SETUP_W-1:0]    setup_sat [N_GROUP];
    logic [PULSE_W-1:0]    pulse_sat [N_GROUP];
    logic [CYCLE_W-1:0]    per_sat   [2];
    logic [SETUP_W-1:0]    setup_q   [N_GROUP];
    logic [PULSE_W-1:0]    pulse_q   [N_GROUP];
    logic [CYCLE_W-1:0]    period_q  [2];
    logic                  done_q;

    function automatic logic [SUM_W-1:0] max3(input logic [SUM_W-1:0] a,
                                              input logic [SUM_W-1:0] b,
                                              input logic [SUM_W-1:0] c);
        logic [SUM_W-1:0] m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic [SUM_W-1:0] tri_sum(input logic [RAW_W-1:0] a,
                                                 input logic [RAW_W-1:0] b,
                                                 input logic [RAW_W-1:0] c);
        return SUM_W'(a) + SUM_W'(b) + SUM_W'(c);
    endfunction

    always_comb begin
        ns_live[IX_RCS_SETUP]    = rcs_setup_ns_i;
        ns_live[IX_RSTB_SETUP]   = rstb_setup_ns_i;
        ns_live[IX_WCS_SETUP]    = wcs_setup_ns_i;
        ns_live[IX_WSTB_SETUP]   = wstb_setup_ns_i;
        ns_live[IX_RCS_PULSE]    = rcs_pulse_ns_i;
        ns_live[IX_RSTB_PULSE]   = rstb_pulse_ns_i;
        ns_live[IX_WCS_PULSE]    = wcs_pulse_ns_i;
        ns_live[IX_WSTB_PULSE]   = wstb_pulse_ns_i;
        ns_live[IX_RD_PERIOD]    = rd_period_ns_i;
        ns_live[IX_WR_PERIOD]    = wr_period_ns_i;
        ns_live[IX_RCS_RECOVER]  = rcs_recover_ns_i;
        ns_live[IX_RSTB_RECOVER] = rstb_recover_ns_i;
        ns_live[IX_WCS_RECOVER]  = wcs_recover_ns_i;
        ns_live[IX_WSTB_RECOVER] = wstb_recover_ns_i;
    end

    assign accept = (state_q == ST_IDLE) && start_i;

    // ---------------- state register ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= ST_IDLE;
        else         state_q <= state_d;
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:       if (start_i) state_d = ST_SCALE_GO;
            ST_SCALE_GO:   state_d = ST_SCALE_WAIT;
            ST_SCALE_WAIT: if (div_done) state_d = ST_MUL_GO;
            ST_MUL_GO:     state_d = ST_MUL_WAIT;
            ST_MUL_WAIT:   if (div_done) state_d = ST_CONVERT;
            ST_CONVERT:    if (idx_q == ITEM_IDX_W'(N_ITEMS - 1)) state_d = ST_STRETCH;
            ST_STRETCH:    state_d = ST_FINISH;
            ST_FINISH:     state_d = ST_IDLE;
            default:       state_d = ST_IDLE;
        endcase
    end

    // ---------------- shared divider ----------------
    always_comb begin
        div_start = (state_q == ST_SCALE_GO) || (state_q == ST_MUL_GO);
        if (state_q == ST_SCALE_GO) begin
            div_dividend = DIV_W'(freq_q);
            div_divisor  = SCALE_DIV;
        end else begin
            div_dividend = {scale_q[DIV_W-FRAC_W-1:0], {FRAC_W{1'b0}}};
            div_divisor  = MUL_DIV;
        end
    end

    nsc_divider #(.W(DIV_W)) u_div (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .start_i    (div_start),
        .dividend_i (div_dividend),
        .divisor_i  (div_divisor),
        .quotient_o (div_quotient),
        .done_o     (div_done)
    );

    // ---------------- shared multiplier and rounding ----------------
    always_comb begin
        prod       = PROD_W'(ns_q[idx_q]) * PROD_W'(mul_q);
        prod_round = prod + ROUND_UP;
        if (ns_q[idx_q] == '0) begin
            conv_val = (idx_q >= ITEM_IDX_W'(FIRST_RECOVER)) ? RAW_W'(1) : '0;
        end else begin
            conv_val = prod_round[PROD_W-1:FRAC_W];
        end
    end

    always_comb begin
        rd_sum_cs  = tri_sum(raw_q[IX_RCS_SETUP],  raw_q[IX_RCS_PULSE],  raw_q[IX_RCS_RECOVER]);
        rd_sum_stb = tri_sum(raw_q[IX_RSTB_SETUP], raw_q[IX_RSTB_PULSE], raw_q[IX_RSTB_RECOVER]);
        wr_sum_cs  = tri_sum(raw_q[IX_WCS_SETUP],  raw_q[IX_WCS_PULSE],  raw_q[IX_WCS_RECOVER]);
        wr_sum_stb = tri_sum(raw_q[IX_WSTB_SETUP], raw_q[IX_WSTB_PULSE], raw_q[IX_WSTB_RECOVER]);
    end

    // ---------------- datapath registers ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            freq_q  <= '0;
            scale_q <= '0;
            mul_q   <= '0;
            idx_q   <= '0;
            for (int i = 0; i < N_ITEMS; i++) begin
                ns_q[i]  <= '0;
                raw_q[i] <= '0;
            end
            per_q[0] <= '0;
            per_q[1] <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        freq_q <= freq_hz_i;
                        for (int i = 0; i < N_ITEMS; i++) ns_q[i] <= ns_live[i];
                    end
                end
                ST_SCALE_WAIT: if (div_done) scale_q <= div_quotient;
                ST_MUL_WAIT: begin
                    if (div_done) begin
                        mul_q <= div_quotient;
                        idx_q <= '0;
                    end
                end
                ST_CONVERT: begin
                    raw_q[idx_q] <= conv_val;
                    idx_q        <= idx_q + ITEM_IDX_W'(1);
                end
                ST_STRETCH: begin
                    per_q[0] <= max3(SUM_W'(raw_q[IX_RD_PERIOD]), rd_sum_cs, rd_sum_stb);
                    per_q[1] <= max3(SUM_W'(raw_q[IX_WR_PERIOD]), wr_sum_cs, wr_sum_stb);
                end
                default: ;
            endcase
        end
    end

    // ---------------- saturation to field widths ----------------
    for (genvar g = 0; g < N_GROUP; g++) begin : g_group
        nsc_saturate #(.IN_W(RAW_W), .OUT_W(SETUP_W)) u_sat_setup (
            .value_i (raw_q[IX_RCS_SETUP + g]),
            .value_o (setup_sat[g])
        );
        nsc_saturate #(.IN_W(RAW_W), .OUT_W(PULSE_W)) u_sat_pulse (
            .value_i (raw_q[IX_RCS_PULSE + g]),
            .value_o (pulse_sat[g])
        );
    end

    for (genvar p = 0; p < 2; p++) begin : g_period
        nsc_saturate #(.IN_W(SUM_W), .OUT_W(CYCLE_W)) u_sat_period (
            .value_i (per_q[p]),
            .value_o (per_sat[p])
        );
    end

    // ---------------- output registers ----------------
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            done_q <= 1'b0;
            for (int i = 0; i < N_GROUP; i++) begin
                setup_q[i] <= '0;
                pulse_q[i] <= '0;
            end
            period_q[0] <= '0;
            period_q[1] <= '0;
        end else begin
            done_q <= (state_q == ST_FINISH);
            if (accept) begin
                for (int i = 0; i < N_GROUP; i++) begin
                    setup_q[i] <= '0;
                    pulse_q[i] <= '0;
                end
                period_q[0] <= '0;
                period_q[1] <= '0;
            end else if (state_q == ST_FINISH) begin
                for (int i = 0; i < N_GROUP; i++) begin
                    setup_q[i] <= setup_sat[i];
                    pulse_q[i] <= pulse_sat[i];
                end
                period_q[0] <= per_sat[0];
                period_q[1] <= per_sat[1];
            end
        end
    end

    assign rcs_setup_cyc_o  = setup_q[0];
    assign rstb_setup_cyc_o = setup_q[1];
    assign wcs_setup_cyc_o  = setup_q[2];
    assign wstb_setup_cyc_o = setup_q[3];
    assign rcs_pulse_cyc_o  = pulse_q[0];
    assign rstb_pulse_cyc_o = pulse_q[1];
    assign wcs_pulse_cyc_o  = pulse_q[2];
    assign wstb_pulse_cyc_o = pulse_q[3];
    assign rd_period_cyc_o  = period_q[0];
    assign wr_period_cyc_o  = period_q[1];
    assign done_o           = done_q;

    // ---------------- assertions ----------------
    assert_done_single_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    assert_outputs_cleared_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q != ST_IDLE) |->
            (rd_period_cyc_o == '0 && wr_period_cyc_o == '0 &&
             rcs_setup_cyc_o == '0 && wstb_pulse_cyc_o == '0));

    assert_read_stretch_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FINISH) |->
            (per_q[0] >= rd_sum_cs && per_q[0] >= rd_sum_stb &&
             per_q[0] >= SUM_W'(raw_q[IX_RD_PERIOD])));

    assert_write_stretch_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_FINISH) |->
            (per_q[1] >= wr_sum_cs && per_q[1] >= wr_sum_stb &&
             per_q[1] >= SUM_W'(raw_q[IX_WR_PERIOD])));

    assert_recover_floor_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CONVERT && idx_q >= ITEM_IDX_W'(FIRST_RECOVER) && ns_q[idx_q] == '0)
            |=> (raw_q[$past(idx_q)] == RAW_W'(1)));

    assert_busy_start_ignored_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_CONVERT && start_i) |=> (state_q != ST_SCALE_GO));

    assert_done_holds_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (state_q == ST_IDLE && !start_i) |=> $stable(rd_period_cyc_o) && $stable(wr_period_cyc_o));

endmodule

// File: tb/nsc_timing_compiler_tb.sv
module nsc_timing_compiler_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [31:0] freq = '0;
    logic [15:0] ns_d [14];

    logic [5:0] o_rcs_setup, o_rstb_setup, o_wcs_setup, o_wstb_setup;
    logic [6:0] o_rcs_pulse, o_rstb_pulse, o_wcs_pulse, o_wstb_pulse;
    logic [8:0] o_rd_per, o_wr_per;
    logic       done;

    int tests_run = 0;
    int tests_failed = 0;
    int cycle_cnt = 0;

    longint unsigned expv [10];
    longint unsigned actv [10];

    always #5 clk = ~clk;

    nsc_timing_compiler u_dut (
        .clk_i             (clk),
        .rst_ni            (rst_n),
        .start_i           (start),
        .freq_hz_i         (freq),
        .rcs_setup_ns_i    (ns_d[0]),
        .rstb_setup_ns_i   (ns_d[1]),
        .wcs_setup_ns_i    (ns_d[2]),
        .wstb_setup_ns_i   (ns_d[3]),
        .rcs_pulse_ns_i    (ns_d[4]),
        .rstb_pulse_ns_i   (ns_d[5]),
        .wcs_pulse_ns_i    (ns_d[6]),
        .wstb_pulse_ns_i   (ns_d[7]),
        .rd_period_ns_i    (ns_d[8]),
        .wr_period_ns_i    (ns_d[9]),
        .rcs_recover_ns_i  (ns_d[10]),
        .rstb_recover_ns_i (ns_d[11]),
        .wcs_recover_ns_i  (ns_d[12]),
        .wstb_recover_ns_i (ns_d[13]),
        .rcs_setup_cyc_o   (o_rcs_setup),
        .rstb_setup_cyc_o  (o_rstb_setup),
        .wcs_setup_cyc_o   (o_wcs_setup),
        .wstb_setup_cyc_o  (o_wstb_setup),
        .rcs_pulse_cyc_o   (o_rcs_pulse),
        .rstb_pulse_cyc_o  (o_rstb_pulse),
        .wcs_pulse_cyc_o   (o_wcs_pulse),
        .wstb_pulse_cyc_o  (o_wstb_pulse),
        .rd_period_cyc_o   (o_rd_per),
        .wr_period_cyc_o   (o_wr_per),
        .done_o            (done)
    );

    always @(posedge clk) begin
        cycle_cnt <= cycle_cnt + 1;
        if (cycle_cnt > 150000) begin
            tests_run++;
            tests_failed++;
            $display("FAIL watchdog: run did not end, actual=%0d cycles expected<=150000", cycle_cnt);
            $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
            $finish;
        end
    end

    task automatic check(input string req, input string what,
                         input longint unsigned act, input longint unsigned exp);
        tests_run++;
        if (act !== exp) begin
            tests_failed++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic longint unsigned sat(input longint unsigned v, input int w);
        longint unsigned lim = (64'd1 << w) - 1;
        return (v > lim) ? lim : v;
    endfunction

    // Reference from the requirements (R2..R7, R10).
    task automatic model(input longint unsigned f, input logic [15:0] ns [14]);
        longint unsigned m;
        longint unsigned c [14];
        longint unsigned a, b, d;
        m = ((f / 10000) << 16) / 100000;
        for (int i = 0; i < 14; i++) begin
            if (ns[i] == 0) c[i] = (i >= 10) ? 1 : 0;
            else            c[i] = (longint'(ns[i]) * m + 65535) >> 16;
        end
        for (int i = 0; i < 4; i++) begin
            expv[i]     = sat(c[i], 6);
            expv[4 + i] = sat(c[4 + i], 7);
        end
        a = c[8]; b = c[0] + c[4] + c[10]; d = c[1] + c[5] + c[11];
        if (b > a) a = b;
        if (d > a) a = d;
        expv[8] = sat(a, 9);
        a = c[9]; b = c[2] + c[6] + c[12]; d = c[3] + c[7] + c[13];
        if (b > a) a = b;
        if (d > a) a = d;
        expv[9] = sat(a, 9);
    endtask

    task automatic grab();
        actv[0] = o_rcs_setup;  actv[1] = o_rstb_setup;
        actv[2] = o_wcs_setup;  actv[3] = o_wstb_setup;
        actv[4] = o_rcs_pulse;  actv[5] = o_rstb_pulse;
        actv[6] = o_wcs_pulse;  actv[7] = o_wstb_pulse;
        actv[8] = o_rd_per;     actv[9] = o_wr_per;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    // Waits for done (sampled on falling edges), checks pulse and hold.
    task automatic wait_done(output int seen);
        int n = 0;
        seen = 0;
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
        end
        if (done) seen = 1;
        check("R9", "done observed", seen, 1);
        grab();
        @(negedge clk);
        check("R9", "done width one clock", done, 0);
    endtask

    task automatic compare_all(input string tag);
        for (int i = 0; i < 10; i++) begin
            string req;
            req = (i < 8) ? "R3" : ((i == 8) ? "R6" : "R7");
            check(req, $sformatf("%s field %0d", tag, i), actv[i], expv[i]);
        end
    endtask

    task automatic run_case(input string tag, input logic [31:0] f, input logic [15:0] ns [14]);
        int seen;
        freq = f;
        for (int i = 0; i < 14; i++) ns_d[i] = ns[i];
        model(f, ns);
        pulse_start();
        repeat (4) @(negedge clk);
        check("R8", {tag, " rd period cleared"}, o_rd_per, 0);
        check("R8", {tag, " setup cleared"}, o_rstb_setup, 0);
        wait_done(seen);
        compare_all(tag);
        repeat (3) @(negedge clk);
        check("R9", {tag, " rd period held"}, o_rd_per, actv[8]);
        check("R9", {tag, " wr period held"}, o_wr_per, actv[9]);
    endtask

    task automatic t_reset();
        check("R1", "reset rd period", o_rd_per, 0);
        check("R1", "reset wr period", o_wr_per, 0);
        check("R1", "reset setup", o_rcs_setup, 0);
        check("R1", "reset pulse", o_wstb_pulse, 0);
        check("R1", "reset done", done, 0);
    endtask

    task automatic t_typical();
        logic [15:0] v [14] = '{10, 20, 5, 15, 40, 35, 45, 30, 60, 70, 7, 12, 9, 3};
        run_case("typical100M", 32'd100_000_000, v);
        // R2: at 100 MHz M = 6553, so 40 ns -> ceil(262120/65536) = 4
        check("R2", "scale via 40ns pulse", actv[4], 4);
    endtask

    task automatic t_zeros();
        logic [15:0] v [14] = '{default: 0};
        run_case("allzero", 32'd50_000_000, v);
        check("R4", "zero setup gives zero", actv[0], 0);
        check("R4", "zero pulse gives zero", actv[7], 0);
        check("R5", "zero recovery read period one", actv[8], 1);
        check("R5", "zero recovery write period one", actv[9], 1);
    endtask

    task automatic t_stretch();
        logic [15:0] v [14] = '{30, 10, 10, 60, 50, 20, 20, 80, 10, 10, 40, 0, 0, 50};
        run_case("stretch133M", 32'd133_000_000, v);
        check("R6", "read period exceeds min", (actv[8] > 2) ? 1 : 0, 1);
        check("R7", "write period exceeds min", (actv[9] > 2) ? 1 : 0, 1);
    endtask

    task automatic t_min_dominates();
        logic [15:0] v [14] = '{5, 5, 5, 5, 10, 10, 10, 10, 900, 700, 5, 5, 5, 5};
        run_case("mindom66M", 32'd66_000_000, v);
    endtask

    task automatic t_saturate();
        logic [15:0] v [14] = '{1000, 100, 1000, 20, 2000, 300, 50, 2000, 60000, 100, 0, 0, 0, 0};
        run_case("sat200M", 32'd200_000_000, v);
        check("R10", "setup clamps at 63", actv[0], 63);
        check("R10", "pulse clamps at 127", actv[4], 127);
        check("R10", "read period clamps at 511", actv[8], 511);
    endtask

    task automatic t_low_freq();
        logic [15:0] v [14] = '{100, 200, 300, 400, 500, 600, 700, 800, 900, 1000, 0, 50, 0, 50};
        run_case("lowfreq", 32'd5000, v);
        check("R3", "scale zero gives zero setup", actv[3], 0);
        check("R5", "nonzero recovery at scale zero", actv[8], 1);
    endtask

    task automatic t_busy_start();
        logic [15:0] v1 [14] = '{20, 20, 20, 20, 30, 30, 30, 30, 100, 100, 10, 10, 10, 10};
        int seen;
        freq = 32'd100_000_000;
        for (int i = 0; i < 14; i++) ns_d[i] = v1[i];
        model(32'd100_000_000, v1);
        pulse_start();
        repeat (10) @(negedge clk);
        freq = 32'd25_000_000;
        for (int i = 0; i < 14; i++) ns_d[i] = 16'd400;
        pulse_start();
        wait_done(seen);
        for (int i = 0; i < 10; i++)
            check("R11", $sformatf("busy start ignored field %0d", i), actv[i], expv[i]);
        repeat (300) @(negedge clk);
        check("R11", "no second done", done, 0);
        check("R11", "results unchanged later", o_rd_per, actv[8]);
    endtask

    initial begin
        for (int i = 0; i < 14; i++) ns_d[i] = '0;
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_typical();
        t_zeros();
        t_stretch();
        t_min_dominates();
        t_saturate();
        t_low_freq();
        t_busy_start();
        $display("  [TB] %0d tests run, %0d failed", tests_run, tests_failed);
        $finish;
    end

endmodule